// File: doc/BRIEF.md
# Bridge Quiesce And Reset Sequencer

This block brings one sub-block of an already powered domain into service and takes it out again. On a bring-up command it holds the sub-block in reset and runs its clock for a fixed number of cycles, so that the reset reaches every flop. It then stops the clock, releases reset and turns the clock back on. Last, it opens the sub-block's master-side bus bridge and then its slave-side bridge.

Each bridge is opened or closed through a stop-request output and an acknowledge input, in a four-phase exchange. To close a bridge the block raises stop-request and waits for acknowledge to rise. To open it the block drops stop-request and waits for acknowledge to fall. Each wait has a cycle limit. Take-down closes the slave bridge first, then the master bridge, gates the clock and asserts reset.

A failed step rolls back as far as is safe and is reported as a failure code. A reset-pulse command is a full take-down followed by a full bring-up. A build without bridges skips both exchanges.

Top module: `bridge_quiesce_seq`

## Requirements
- R1: After reset: clock enable low, sub-block reset asserted (low), both stop-requests high, busy low, in-service low, failure code 0.
- R2: Bring-up holds reset low with the clock enabled for exactly BURST_CYCLES cycles. The clock is then disabled before reset is released, and re-enabled after the release and before any stop-request falls.
- R3: Bring-up drops the master stop-request and waits for the master acknowledge to go low. Only then does it drop the slave stop-request and wait for that acknowledge to go low. On success: in-service 1, failure code 0, clock on, reset released.
- R4: If the master acknowledge stays high for TIMEOUT_CYCLES cycles during bring-up, the failure code is 1. The master stop-request goes high again, the clock is gated, then reset is asserted and in-service is 0.
- R5: If the slave acknowledge stays high for TIMEOUT_CYCLES cycles during bring-up, the failure code is 2. The slave stop-request goes high and the master bridge is closed again through its exchange. Then the clock is gated, reset is asserted and in-service is 0.
- R6: Take-down raises the slave stop-request before the master one. After both are acknowledged the clock is gated at least one cycle before reset falls, and in-service becomes 0.
- R7: If the slave does not acknowledge a stop within TIMEOUT_CYCLES cycles, the failure code is 3 and the sequence ends. The clock stays on, reset stays released, the master stop-request stays low and in-service stays 1.
- R8: If the master does not acknowledge a stop in time, the failure code is 4. The slave stop-request is dropped again, the clock stays on, reset stays released and in-service stays 1.
- R9: A reset-pulse command (op 3) on an in-service block runs a take-down then a bring-up. On a block out of service it runs only the bring-up. If the take-down fails, no bring-up follows.
- R10: A bring-up command (op 1) on an in-service block, or a take-down command (op 2) on an idle block, completes with done on the next cycle, failure code 0 and no output change. Op 0 does nothing.
- R11: With HAS_BRIDGES = 0 both stop-request outputs stay high, the acknowledge inputs are ignored, and both sequences complete with failure code 0.
- R12: A command presented while busy is ignored.
- R13: Every accepted command produces exactly one single-cycle done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 0 none, 1 bring-up, 2 take-down, 3 reset pulse |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| in_service | output | 1 | Sub-block is up with both bridges open |
| fail_code | output | 3 | 0 ok, 1 master open, 2 slave open, 3 slave close, 4 master close |
| sub_clk_en | output | 1 | Sub-block clock enable |
| sub_rst_n | output | 1 | Sub-block reset, active low |
| mst_stop_req | output | 1 | Master bridge stop-request |
| mst_stop_ack | input | 1 | Master bridge acknowledge |
| slv_stop_req | output | 1 | Slave bridge stop-request |
| slv_stop_ack | input | 1 | Slave bridge acknowledge |

## Verification
The bench sweeps every pair of master and slave acknowledge latencies from 0 to 3 cycles. It checks that the burst length is exact and that the clock, reset and bridge events occur in the required order. A design that let reset go while the clock ran, or opened the slave first, would show those events out of order.

Stuck acknowledges are forced at each of the four exchanges. A design with a wrong rollback would leave a bridge open, gate the clock on a failed close, or fail to reclose the master. The open windows are counted to catch an off-by-one timeout.

No-op commands, commands given while busy, and the bridgeless build are also exercised. A design that got these wrong would produce spurious bursts, extra done pulses, or wait on acknowledges that never come.

// File: rtl/bqs_pkg.sv
package bqs_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_UP    = 2'd1,
        OP_DOWN  = 2'd2,
        OP_PULSE = 2'd3
    } bqs_op_e;

    typedef enum logic [2:0] {
        FAIL_NONE     = 3'd0,
        FAIL_MST_OPEN = 3'd1,
        FAIL_SLV_OPEN = 3'd2,
        FAIL_SLV_SHUT = 3'd3,
        FAIL_MST_SHUT = 3'd4
    } bqs_fail_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BURST,    // clock on, reset held
        ST_HOLD,     // clock off, reset held
        ST_WAKE,     // clock off, reset released
        ST_RUN,      // clock on again
        ST_MST_OPEN,
        ST_SLV_OPEN,
        ST_MST_RESHUT,
        ST_GATE,     // clock off, reset still released
        ST_CLAMP,    // reset asserted
        ST_SLV_SHUT,
        ST_MST_SHUT,
        ST_SLV_REOPEN
    } bqs_state_e;

    typedef struct packed {
        bqs_state_e st;
        logic       clk_en;
        logic       rst_n;
        logic       mreq;
        logic       sreq;
        logic       live;
        logic       busy;
        logic       done;
        logic       pulse;
        bqs_fail_e  fail;
    } bqs_ctl_t;

endpackage

// File: rtl/bqs_cycle_timer.sv
module bqs_cycle_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart_i)
            cnt_d = '0;
        else if (cnt_q == {CW{1'b1}})
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q >= (limit_i - CW'(1)));

endmodule

// File: rtl/bqs_ack_watch.sv
module bqs_ack_watch #(
    parameter int STAGES  = 2,
    parameter bit PRESENT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    input  logic req_i,
    output logic settled_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb sync_d = {sync_q[STAGES-2:0], ack_i};

    // bridges come out of reset closed, so the acknowledge starts high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    generate
        if (PRESENT) begin : g_live
            assign settled_o = (sync_q[STAGES-1] == req_i);
        end else begin : g_absent
            assign settled_o = 1'b1 | (sync_q[STAGES-1] & req_i);
        end
    endgenerate

endmodule

// File: rtl/bridge_quiesce_seq.sv
module bridge_quiesce_seq
    import bqs_pkg::*;
#(
    parameter int BURST_CYCLES   = 32,
    parameter int TIMEOUT_CYCLES = 64,
    parameter int SYNC_STAGES    = 2,
    parameter bit HAS_BRIDGES    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       busy,
    output logic       done,
    output logic       in_service,
    output logic [2:0] fail_code,
    output logic       sub_clk_en,
    output logic       sub_rst_n,
    output logic       mst_stop_req,
    input  logic       mst_stop_ack,
    output logic       slv_stop_req,
    input  logic       slv_stop_ack
);
    localparam int MAXC = (BURST_CYCLES > TIMEOUT_CYCLES) ? BURST_CYCLES : TIMEOUT_CYCLES;
    localparam int CW   = $clog2(MAXC + 1) + 1;
    localparam logic [CW-1:0] BURST_L = CW'(BURST_CYCLES);
    localparam logic [CW-1:0] WAIT_L  = CW'(TIMEOUT_CYCLES);

    bqs_ctl_t q, d;
    logic     m_settled, s_settled, expired, restart;
    logic [CW-1:0] limit;
    bqs_op_e  op;

    assign op      = bqs_op_e'(cmd_op);
    assign limit   = (q.st == ST_BURST) ? BURST_L : WAIT_L;
    assign restart = (d.st != q.st);

    bqs_cycle_timer #(.CW(CW)) i_timer (
        .clk(clk), .rst_n(rst_n), .restart_i(restart),
        .limit_i(limit), .expired_o(expired)
    );

    bqs_ack_watch #(.STAGES(SYNC_STAGES), .PRESENT(HAS_BRIDGES)) i_mst_watch (
        .clk(clk), .rst_n(rst_n), .ack_i(mst_stop_ack),
        .req_i(q.mreq), .settled_o(m_settled)
    );

    bqs_ack_watch #(.STAGES(SYNC_STAGES), .PRESENT(HAS_BRIDGES)) i_slv_watch (
        .clk(clk), .rst_n(rst_n), .ack_i(slv_stop_ack),
        .req_i(q.sreq), .settled_o(s_settled)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid && (op != OP_NONE)) begin
                    d.fail = FAIL_NONE;
                    if ((op == OP_UP && q.live) || (op == OP_DOWN && !q.live)) begin
                        d.done = 1'b1;
                    end else begin
                        d.busy  = 1'b1;
                        d.pulse = (op == OP_PULSE);
                        if (q.live) begin
                            d.st   = ST_SLV_SHUT;
                            d.sreq = 1'b1;
                        end else begin
                            d.st     = ST_BURST;
                            d.clk_en = 1'b1;
                        end
                    end
                end
            end
            ST_BURST: if (expired) begin
                d.st     = ST_HOLD;
                d.clk_en = 1'b0;
            end
            ST_HOLD: begin
                d.st    = ST_WAKE;
                d.rst_n = 1'b1;
            end
            ST_WAKE: begin
                d.st     = ST_RUN;
                d.clk_en = 1'b1;
            end
            ST_RUN: begin
                d.st   = ST_MST_OPEN;
                d.mreq = 1'b0;
            end
            ST_MST_OPEN: begin
                if (m_settled) begin
                    d.st   = ST_SLV_OPEN;
                    d.sreq = 1'b0;
                end else if (expired) begin
                    d.fail   = FAIL_MST_OPEN;
                    d.mreq   = 1'b1;
                    d.st     = ST_GATE;
                    d.clk_en = 1'b0;
                end
            end
            ST_SLV_OPEN: begin
                if (s_settled) begin
                    d.st    = ST_IDLE;
                    d.live  = 1'b1;
                    d.busy  = 1'b0;
                    d.pulse = 1'b0;
                    d.done  = 1'b1;
                end else if (expired) begin
                    d.fail = FAIL_SLV_OPEN;
                    d.sreq = 1'b1;
                    d.mreq = 1'b1;
                    d.st   = ST_MST_RESHUT;
                end
            end
            ST_MST_RESHUT: if (m_settled || expired) begin
                d.st     = ST_GATE;
                d.clk_en = 1'b0;
            end
            ST_GATE: begin
                d.st    = ST_CLAMP;
                d.rst_n = 1'b0;
                d.live  = 1'b0;
            end
            ST_CLAMP: begin
                if (q.pulse && q.fail == FAIL_NONE) begin
                    d.st     = ST_BURST;
                    d.clk_en = 1'b1;
                end else begin
                    d.st    = ST_IDLE;
                    d.busy  = 1'b0;
                    d.pulse = 1'b0;
                    d.done  = 1'b1;
                end
            end
            ST_SLV_SHUT: begin
                if (s_settled) begin
                    d.st   = ST_MST_SHUT;
                    d.mreq = 1'b1;
                end else if (expired) begin
                    d.fail  = FAIL_SLV_SHUT;
                    d.st    = ST_IDLE;
                    d.busy  = 1'b0;
                    d.pulse = 1'b0;
                    d.done  = 1'b1;
                end
            end
            ST_MST_SHUT: begin
                if (m_settled) begin
                    d.st     = ST_GATE;
                    d.clk_en = 1'b0;
                end else if (expired) begin
                    d.fail = FAIL_MST_SHUT;
                    d.sreq = 1'b0;
                    d.st   = ST_SLV_REOPEN;
                end
            end
            ST_SLV_REOPEN: if (s_settled || expired) begin
                d.st    = ST_IDLE;
                d.busy  = 1'b0;
                d.pulse = 1'b0;
                d.done  = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.mreq   <= 1'b1;
            q.sreq   <= 1'b1;
            q.fail   <= FAIL_NONE;
        end else begin
            q <= d;
        end
    end

    assign busy       = q.busy;
    assign done       = q.done;
    assign in_service = q.live;
    assign fail_code  = q.fail;
    assign sub_clk_en = q.clk_en;
    assign sub_rst_n  = q.rst_n;

    generate
        if (HAS_BRIDGES) begin : g_req
            assign mst_stop_req = q.mreq;
            assign slv_stop_req = q.sreq;
        end else begin : g_noreq
            assign mst_stop_req = 1'b1;
            assign slv_stop_req = 1'b1;
        end
    endgenerate

    assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    assert_release_clock_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rst_n) |-> !q.clk_en);

    assert_reset_after_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rst_n) |-> (!q.clk_en && !$past(q.clk_en)));

    assert_open_needs_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.mreq) |-> (q.clk_en && q.rst_n));

    assert_slave_after_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.sreq) && q.st == ST_SLV_OPEN) |-> !q.mreq);

endmodule

// File: tb/test_bridge_quiesce_seq.sv
`timescale 1ns/1ps
module test_bridge_quiesce_seq;
    localparam int B  = 6;
    localparam int TO = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic       busy, done, in_service, sub_clk_en, sub_rst_n;
    logic [2:0] fail_code;
    logic       mst_stop_req, slv_stop_req, mst_stop_ack, slv_stop_ack;

    logic       nb_valid = 1'b0;
    logic [1:0] nb_op = 2'd0;
    logic       nb_busy, nb_done, nb_live, nb_clk, nb_rst, nb_mreq, nb_sreq;
    logic [2:0] nb_fail;

    bridge_quiesce_seq #(.BURST_CYCLES(B), .TIMEOUT_CYCLES(TO)) i_bridge_quiesce_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .busy(busy), .done(done), .in_service(in_service), .fail_code(fail_code),
        .sub_clk_en(sub_clk_en), .sub_rst_n(sub_rst_n),
        .mst_stop_req(mst_stop_req), .mst_stop_ack(mst_stop_ack),
        .slv_stop_req(slv_stop_req), .slv_stop_ack(slv_stop_ack)
    );

    bridge_quiesce_seq #(.BURST_CYCLES(B), .TIMEOUT_CYCLES(TO), .HAS_BRIDGES(1'b0)) i_nobridge (
        .clk(clk), .rst_n(rst_n), .cmd_valid(nb_valid), .cmd_op(nb_op),
        .busy(nb_busy), .done(nb_done), .in_service(nb_live), .fail_code(nb_fail),
        .sub_clk_en(nb_clk), .sub_rst_n(nb_rst),
        .mst_stop_req(nb_mreq), .mst_stop_ack(1'b0),
        .slv_stop_req(nb_sreq), .slv_stop_ack(1'b0)
    );

    // bridge models: acknowledge follows the request after a latency, or is stuck
    int   lat_m = 0, lat_s = 0;
    logic stk_m = 1'b0, stv_m = 1'b0, stk_s = 1'b0, stv_s = 1'b0;
    logic [7:0] hm = 8'hFF, hs = 8'hFF;
    always @(posedge clk) begin
        hm <= {hm[6:0], mst_stop_req};
        hs <= {hs[6:0], slv_stop_req};
    end
    always_comb begin
        if (stk_m)           mst_stop_ack = stv_m;
        else if (lat_m == 0) mst_stop_ack = mst_stop_req;
        else                 mst_stop_ack = hm[lat_m-1];
        if (stk_s)           slv_stop_ack = stv_s;
        else if (lat_s == 0) slv_stop_ack = slv_stop_req;
        else                 slv_stop_ack = hs[lat_s-1];
    end

    // monitor, sampling on the falling edge
    int cyc = 0, burst_cnt = 0, mlow = 0, slow = 0, done_cnt = 0;
    int t_mfall = 0, t_sfall = 0, t_mrise = 0, t_srise = 0;
    int t_rrise = 0, t_rfall = 0, t_crise = 0, t_cfall = 0;
    logic p_c = 1'b0, p_r = 1'b0, p_m = 1'b1, p_s = 1'b1;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sub_clk_en && !sub_rst_n) burst_cnt = burst_cnt + 1;
        if (!mst_stop_req) mlow = mlow + 1;
        if (!slv_stop_req) slow = slow + 1;
        if (done) done_cnt = done_cnt + 1;
        if (p_m && !mst_stop_req) t_mfall = cyc;
        if (!p_m && mst_stop_req) t_mrise = cyc;
        if (p_s && !slv_stop_req) t_sfall = cyc;
        if (!p_s && slv_stop_req) t_srise = cyc;
        if (!p_r && sub_rst_n) t_rrise = cyc;
        if (p_r && !sub_rst_n) t_rfall = cyc;
        if (!p_c && sub_clk_en) t_crise = cyc;
        if (p_c && !sub_clk_en) t_cfall = cyc;
        p_c = sub_clk_en; p_r = sub_rst_n; p_m = mst_stop_req; p_s = slv_stop_req;
    end

    int checks = 0, errors = 0;
    int c0, b0, ml0, sl0, d0, wait_n;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic start_cmd(input bit nb, input logic [1:0] op);
        @(posedge clk); #1;
        c0 = cyc; b0 = burst_cnt; ml0 = mlow; sl0 = slow; d0 = done_cnt;
        if (nb) begin nb_valid = 1'b1; nb_op = op; end
        else    begin cmd_valid = 1'b1; cmd_op = op; end
        @(posedge clk); #1;
        nb_valid = 1'b0; cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input bit nb);
        wait_n = 0;
        forever begin
            @(negedge clk);
            if (nb ? nb_done : done) break;
            wait_n++;
            if (wait_n > 400) begin
                errors++;
                $display("FAIL R13: got no done, expected a done pulse");
                break;
            end
        end
        @(posedge clk); #1;
    endtask

    task automatic run_cmd(input logic [1:0] op);
        start_cmd(1'b0, op);
        wait_done(1'b0);
        chk("R13 one done pulse", done_cnt - d0, 1);
    endtask

    task automatic chk_pins(input string tag, input int c, input int r, input int m,
                            input int s, input int l, input int f);
        chk({tag, " clk_en"}, int'(sub_clk_en), c);
        chk({tag, " rst_n"}, int'(sub_rst_n), r);
        chk({tag, " mst_req"}, int'(mst_stop_req), m);
        chk({tag, " slv_req"}, int'(slv_stop_req), s);
        chk({tag, " live"}, int'(in_service), l);
        chk({tag, " fail"}, int'(fail_code), f);
    endtask

    initial begin
        #1200000;
        errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        summary();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        chk_pins("R1 in reset", 0, 0, 1, 1, 0, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk_pins("R1 after reset", 0, 0, 1, 1, 0, 0);
        chk("R1 busy", int'(busy), 0);

        // op 0 does nothing
        start_cmd(1'b0, 2'd0);
        repeat (4) @(posedge clk); #1;
        chk("R10 op none no done", done_cnt - d0, 0);
        chk("R10 op none no burst", burst_cnt - b0, 0);

        // latency sweep
        for (int lm = 0; lm < 4; lm++) begin
            for (int ls = 0; ls < 4; ls++) begin
                lat_m = lm; lat_s = ls;
                run_cmd(2'd1);
                chk_pins("R3 up", 1, 1, 0, 0, 1, 0);
                chk("R2 burst length", burst_cnt - b0, B);
                chk("R2 clock off before release", int'(t_cfall < t_rrise && t_cfall > c0), 1);
                chk("R2 clock back before open", int'(t_crise > t_rrise && t_crise < t_mfall), 1);
                chk("R3 master before slave", int'(t_mfall > c0 && t_mfall < t_sfall), 1);
                run_cmd(2'd2);
                chk_pins("R6 down", 0, 0, 1, 1, 0, 0);
                chk("R6 slave shut first", int'(t_srise > c0 && t_srise < t_mrise), 1);
                chk("R6 gate before reset", int'(t_cfall > c0 && t_cfall < t_rfall), 1);
            end
        end
        lat_m = 1; lat_s = 2;

        // master open timeout
        stk_m = 1'b1; stv_m = 1'b1;
        run_cmd(2'd1);
        chk_pins("R4 master open fail", 0, 0, 1, 1, 0, 1);
        chk("R4 wait window", mlow - ml0, TO);
        chk("R4 slave never opened", slow - sl0, 0);
        stk_m = 1'b0;
        repeat (10) @(posedge clk);

        // slave open timeout, master reclosed
        stk_s = 1'b1; stv_s = 1'b1;
        run_cmd(2'd1);
        chk_pins("R5 slave open fail", 0, 0, 1, 1, 0, 2);
        chk("R5 wait window", slow - sl0, TO);
        chk("R5 master reclosed", int'(t_mrise > t_mfall && t_mfall > c0), 1);
        stk_s = 1'b0;
        repeat (10) @(posedge clk);

        // slave shut timeout
        run_cmd(2'd1);
        chk_pins("R3 up again", 1, 1, 0, 0, 1, 0);
        stk_s = 1'b1; stv_s = 1'b0;
        run_cmd(2'd2);
        chk_pins("R7 slave shut fail", 1, 1, 0, 1, 1, 3);
        stk_s = 1'b0;
        repeat (10) @(posedge clk);
        run_cmd(2'd2);
        chk_pins("R6 down after R7", 0, 0, 1, 1, 0, 0);

        // master shut timeout, slave reopened
        run_cmd(2'd1);
        stk_m = 1'b1; stv_m = 1'b0;
        run_cmd(2'd2);
        chk_pins("R8 master shut fail", 1, 1, 1, 0, 1, 4);
        chk("R8 slave reopened", int'(t_sfall > t_srise && t_srise > c0), 1);
        stk_m = 1'b0;
        repeat (10) @(posedge clk);
        run_cmd(2'd2);
        chk_pins("R6 down after R8", 0, 0, 1, 1, 0, 0);

        // reset pulse from idle, then from in service
        run_cmd(2'd3);
        chk_pins("R9 pulse from idle", 1, 1, 0, 0, 1, 0);
        chk("R9 idle pulse burst", burst_cnt - b0, B);
        run_cmd(2'd3);
        chk_pins("R9 pulse from live", 1, 1, 0, 0, 1, 0);
        chk("R9 reset fell", int'(t_rfall > c0 && t_rrise > t_rfall), 1);
        chk("R9 live pulse burst", burst_cnt - b0, B);
        stk_s = 1'b1; stv_s = 1'b0;
        run_cmd(2'd3);
        chk_pins("R9 pulse abort", 1, 1, 0, 1, 1, 3);
        chk("R9 no burst after abort", burst_cnt - b0, 0);
        stk_s = 1'b0;
        repeat (10) @(posedge clk);

        // no-op commands
        run_cmd(2'd1);
        chk_pins("R10 up while live", 1, 1, 0, 1, 1, 0);
        chk("R10 immediate done", int'(wait_n <= 1), 1);
        chk("R10 no burst", burst_cnt - b0, 0);
        run_cmd(2'd2);
        chk_pins("R6 down", 0, 0, 1, 1, 0, 0);
        run_cmd(2'd2);
        chk_pins("R10 down while idle", 0, 0, 1, 1, 0, 0);
        chk("R10 immediate done idle", int'(wait_n <= 1), 1);

        // command during busy is ignored
        start_cmd(1'b0, 2'd1);
        chk("R12 busy", int'(busy), 1);
        repeat (2) @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_op = 2'd2;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        wait_done(1'b0);
        chk_pins("R12 busy ignore", 1, 1, 0, 0, 1, 0);
        repeat (40) @(posedge clk); #1;
        chk("R12 single done", done_cnt - d0, 1);
        chk("R12 still live", int'(in_service), 1);

        // bridgeless build
        start_cmd(1'b1, 2'd1);
        wait_done(1'b1);
        chk("R11 up live", int'(nb_live), 1);
        chk("R11 up fail", int'(nb_fail), 0);
        chk("R11 up clk", int'(nb_clk), 1);
        chk("R11 up rst", int'(nb_rst), 1);
        chk("R11 mreq high", int'(nb_mreq), 1);
        chk("R11 sreq high", int'(nb_sreq), 1);
        start_cmd(1'b1, 2'd2);
        wait_done(1'b1);
        chk("R11 down live", int'(nb_live), 0);
        chk("R11 down fail", int'(nb_fail), 0);
        chk("R11 down rst", int'(nb_rst), 0);
        chk("R11 reqs high", int'(nb_mreq & nb_sreq), 1);

        summary();
    end
endmodule